// File: doc/BRIEF.md
# DMA Window Address Decoder

This block sits behind the target side of a PCI bridge and decides whether an inbound memory access belongs to system memory. It compares each request address with four programmable windows. A hit forwards a request toward the upstream system bus. A miss, or a hit on a scatter/gather page that is not valid, raises an error pulse and forwards nothing.

When a window hits, the block translates the address to a system address. A window can translate in one of two ways. A direct window adds its translated base to the offset within the window. A scatter/gather window replaces the page number with a page frame taken from a shared 64-entry map. The block also picks the upstream command. A read is always a whole 64-byte memory block, and a read with PCI lock held becomes an interlocked read. Writes are sent as masked or unmasked, depending on whether every byte lane is enabled.

Software sets up the windows and the map through a single register write port. Each request produces its result one clock later.

Top module: `dwd_window_decoder`

## Requirements
- R1: While reset is held and after it is released, `fwd_valid`, `err_valid`, `fwd_addr`, `fwd_cmd` and `fwd_win` are all zero.
- R2: Window w hits when its enable bit is set and `(req_addr ^ base) & mask` is zero. A window whose enable bit is clear never hits.
- R3: When several windows hit, the lowest-numbered one is used, and its number appears on `fwd_win`.
- R4: On a direct window, the system address is the window's translated base plus `req_addr & ~mask`.
- R5: On a scatter/gather window, map index = `req_addr[18:13]` and system address = `{pfn, req_addr[12:0]}`. A map entry is written with valid in `cfg_wdata[31]` and pfn in `cfg_wdata[18:0]`.
- R6: A request that hits no window, or whose winning window uses scatter/gather with an invalid entry, gives `err_valid`=1 and `fwd_valid`=0 on the next cycle.
- R7: `fwd_cmd` uses these encodings:
  - 0 is a read.
  - 1 is a write with some byte lanes disabled.
  - 2 is a write with all lanes enabled.
  - 3 is a read with `req_lock` set.
  - `req_lock` has no effect on writes.
- R8: For reads, `fwd_addr[5:0]` is zero, which aligns the address to a 64-byte block. Writes carry the full translated address.
- R9: Results appear on the cycle after `req_valid`. A register write in the same cycle as a request does not affect that request, and it does affect the next one.
- R10: The configuration select codes are:
  - 0 selects base.
  - 1 selects mask.
  - 2 selects translated base.
  - 3 selects control, with enable at bit 0 and scatter/gather at bit 1.
  - 4 selects a map entry.
  - For the window registers, `cfg_idx[1:0]` picks the window. For a map entry, `cfg_idx` is the entry index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select code |
| cfg_idx | input | 6 | Window number or map entry index |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Inbound memory request present |
| req_addr | input | 32 | PCI memory address |
| req_is_write | input | 1 | 1 for a write, 0 for a read |
| req_full | input | 1 | All byte lanes enabled (writes) |
| req_lock | input | 1 | PCI lock held |
| fwd_valid | output | 1 | Upstream request issued |
| fwd_addr | output | 32 | Translated system address |
| fwd_cmd | output | 2 | Upstream command code |
| fwd_win | output | 2 | Window that produced the hit |
| err_valid | output | 1 | Request rejected |

## Verification
A register write and a request can arrive on the same edge. If the write retargets the very window that the request hits, the request could end up with either the old or the new translation. The bench provokes this by issuing a request in the same cycle as a write that clears the enable bit of the winning window. It judges the result by expecting the old window and its translation on that result. On the following request it expects the next window to take over.

// File: rtl/dwd_pkg.sv
package dwd_pkg;

  typedef enum logic [1:0] {
    UP_READ      = 2'd0,
    UP_WR_MASKED = 2'd1,
    UP_WR_FULL   = 2'd2,
    UP_READ_LOCK = 2'd3
  } up_cmd_e;

  localparam logic [2:0] SEL_BASE  = 3'd0;
  localparam logic [2:0] SEL_MASK  = 3'd1;
  localparam logic [2:0] SEL_TBASE = 3'd2;
  localparam logic [2:0] SEL_CTRL  = 3'd3;
  localparam logic [2:0] SEL_SGENT = 3'd4;

  function automatic up_cmd_e pick_cmd(input logic is_write, input logic full,
                                       input logic lock);
    if (is_write) return full ? UP_WR_FULL : UP_WR_MASKED;
    return lock ? UP_READ_LOCK : UP_READ;
  endfunction

endpackage

// File: rtl/dwd_win_regs.sv
module dwd_win_regs #(
  parameter int NUM_WIN = 4,
  parameter int ADDR_W  = 32,
  parameter int SYS_W   = 32,
  localparam int WIN_IW = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [WIN_IW-1:0] cfg_win,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic [ADDR_W-1:0] req_addr,
  output logic [NUM_WIN-1:0] hit_vec,
  output logic [NUM_WIN-1:0] grant_vec,
  output logic               any_hit,
  output logic [WIN_IW-1:0]  sel_win,
  output logic [ADDR_W-1:0]  sel_mask,
  output logic [SYS_W-1:0]   sel_tbase,
  output logic               sel_sg
);
  import dwd_pkg::*;

  logic [ADDR_W-1:0] base_q  [NUM_WIN];
  logic [ADDR_W-1:0] mask_q  [NUM_WIN];
  logic [SYS_W-1:0]  tbase_q [NUM_WIN];
  logic [NUM_WIN-1:0] en_q, sgen_q;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic wr_here;
    assign wr_here = cfg_we && (cfg_win == WIN_IW'(w));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q[w]  <= '0;
        mask_q[w]  <= '0;
        tbase_q[w] <= '0;
        en_q[w]    <= 1'b0;
        sgen_q[w]  <= 1'b0;
      end else if (wr_here) begin
        case (cfg_sel)
          SEL_BASE:  base_q[w]  <= cfg_wdata;
          SEL_MASK:  mask_q[w]  <= cfg_wdata;
          SEL_TBASE: tbase_q[w] <= SYS_W'(cfg_wdata);
          SEL_CTRL: begin
            en_q[w]   <= cfg_wdata[0];
            sgen_q[w] <= cfg_wdata[1];
          end
          default: ;
        endcase
      end
    end
    assign hit_vec[w] = en_q[w] && (((req_addr ^ base_q[w]) & mask_q[w]) == '0);
  end

  // lowest-numbered hit wins
  always_comb begin
    grant_vec = '0;
    sel_win   = '0;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (hit_vec[w]) begin
        grant_vec = '0;
        grant_vec[w] = 1'b1;
        sel_win = WIN_IW'(w);
      end
    end
  end

  assign any_hit   = |hit_vec;
  assign sel_mask  = mask_q[sel_win];
  assign sel_tbase = tbase_q[sel_win];
  assign sel_sg    = sgen_q[sel_win];

endmodule

// File: rtl/dwd_sg_map.sv
module dwd_sg_map #(
  parameter int ENTRIES = 64,
  parameter int PFN_W   = 19,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [PFN_W-1:0]  rd_pfn
);
  logic [ENTRIES-1:0] valid_q;
  logic [PFN_W-1:0]   pfn_q [ENTRIES];
  logic unused_wdata;

  assign unused_wdata = ^wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= wr_data[DATA_W-1];
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) pfn_q[wr_idx] <= wr_data[PFN_W-1:0];
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_pfn   = pfn_q[rd_idx];

endmodule

// File: rtl/dwd_window_decoder.sv
module dwd_window_decoder #(
  parameter int NUM_WIN    = 4,
  parameter int ADDR_W     = 32,
  parameter int SYS_W      = 32,
  parameter int PAGE_W     = 13,
  parameter int SG_ENTRIES = 64,
  parameter int BLOCK_W    = 6,
  localparam int WIN_IW    = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
  localparam int SG_IW     = $clog2(SG_ENTRIES),
  localparam int PFN_W     = SYS_W - PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [SG_IW-1:0]  cfg_idx,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_is_write,
  input  logic              req_full,
  input  logic              req_lock,
  output logic              fwd_valid,
  output logic [SYS_W-1:0]  fwd_addr,
  output logic [1:0]        fwd_cmd,
  output logic [WIN_IW-1:0] fwd_win,
  output logic              err_valid
);
  import dwd_pkg::*;

  logic [NUM_WIN-1:0] hit_vec, grant_vec;
  logic               any_hit, sel_sg, sg_valid;
  logic [WIN_IW-1:0]  sel_win;
  logic [ADDR_W-1:0]  sel_mask;
  logic [SYS_W-1:0]   sel_tbase, raw_addr, out_addr;
  logic [PFN_W-1:0]   sg_pfn;
  logic               sg_fault, accept, reject;
  up_cmd_e            cmd_next;

  dwd_win_regs #(.NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .SYS_W(SYS_W)) u_win (
    .clk, .rst_n,
    .cfg_we   (cfg_we && (cfg_sel != SEL_SGENT)),
    .cfg_sel,
    .cfg_win  (cfg_idx[WIN_IW-1:0]),
    .cfg_wdata,
    .req_addr,
    .hit_vec, .grant_vec, .any_hit, .sel_win, .sel_mask, .sel_tbase, .sel_sg
  );

  dwd_sg_map #(.ENTRIES(SG_ENTRIES), .PFN_W(PFN_W), .DATA_W(ADDR_W)) u_map (
    .clk, .rst_n,
    .wr_en   (cfg_we && (cfg_sel == SEL_SGENT)),
    .wr_idx  (cfg_idx),
    .wr_data (cfg_wdata),
    .rd_idx  (req_addr[PAGE_W +: SG_IW]),
    .rd_valid(sg_valid),
    .rd_pfn  (sg_pfn)
  );

  function automatic logic [SYS_W-1:0] direct_xlate(input logic [ADDR_W-1:0] a,
      input logic [ADDR_W-1:0] m, input logic [SYS_W-1:0] tb);
    return tb + SYS_W'(a & ~m);
  endfunction

  function automatic logic [SYS_W-1:0] sg_xlate(input logic [ADDR_W-1:0] a,
      input logic [PFN_W-1:0] pfn);
    return {pfn, a[PAGE_W-1:0]};
  endfunction

  function automatic logic [SYS_W-1:0] block_align(input logic [SYS_W-1:0] a);
    return {a[SYS_W-1:BLOCK_W], {BLOCK_W{1'b0}}};
  endfunction

  assign raw_addr = sel_sg ? sg_xlate(req_addr, sg_pfn)
                           : direct_xlate(req_addr, sel_mask, sel_tbase);
  assign out_addr = req_is_write ? raw_addr : block_align(raw_addr);
  assign sg_fault = any_hit && sel_sg && !sg_valid;
  assign accept   = req_valid && any_hit && !sg_fault;
  assign reject   = req_valid && !accept;
  assign cmd_next = pick_cmd(req_is_write, req_full, req_lock);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fwd_valid <= 1'b0;
      err_valid <= 1'b0;
      fwd_addr  <= '0;
      fwd_cmd   <= '0;
      fwd_win   <= '0;
    end else begin
      fwd_valid <= accept;
      err_valid <= reject;
      if (accept) begin
        fwd_addr <= out_addr;
        fwd_cmd  <= cmd_next;
        fwd_win  <= sel_win;
      end
    end
  end

endmodule

// File: rtl/dwd_checker.sv
module dwd_checker #(
  parameter int NUM_WIN = 4,
  parameter int SYS_W   = 32,
  parameter int BLOCK_W = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_is_write,
  input logic               req_lock,
  input logic [NUM_WIN-1:0] hit_vec,
  input logic [NUM_WIN-1:0] grant_vec,
  input logic               fwd_valid,
  input logic [SYS_W-1:0]   fwd_addr,
  input logic [1:0]         fwd_cmd,
  input logic               err_valid
);
  assert_one_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_vec) && ((grant_vec != '0) == (hit_vec != '0)));

  assert_miss_errs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && hit_vec == '0) |=> (err_valid && !fwd_valid));

  assert_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(fwd_valid && err_valid));

  assert_locked_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_is_write && req_lock) |=> (!fwd_valid || fwd_cmd == 2'd3));

  assert_read_align_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid && fwd_cmd[0] == fwd_cmd[1]) |-> (fwd_addr[BLOCK_W-1:0] == '0));

  assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid || err_valid) |-> $past(req_valid));
endmodule

bind dwd_window_decoder dwd_checker #(.NUM_WIN(NUM_WIN), .SYS_W(SYS_W), .BLOCK_W(BLOCK_W)) u_chk (
  .clk, .rst_n, .req_valid, .req_is_write, .req_lock, .hit_vec, .grant_vec,
  .fwd_valid, .fwd_addr, .fwd_cmd, .err_valid
);

// File: tb/dwd_window_decoder_test.sv
module dwd_window_decoder_test;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [2:0] cfg_sel = 0;
  logic [5:0] cfg_idx = 0;
  logic [31:0] cfg_wdata = 0;
  logic req_valid = 0, req_is_write = 0, req_full = 0, req_lock = 0;
  logic [31:0] req_addr = 0;
  logic fwd_valid, err_valid;
  logic [31:0] fwd_addr;
  logic [1:0] fwd_cmd, fwd_win;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  dwd_window_decoder uut (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [2:0] sel, logic [5:0] idx, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel; cfg_idx = idx; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic issue(logic [31:0] a, logic w, logic f, logic l);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_is_write = w; req_full = f; req_lock = l;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic expect_fwd(string req, logic [31:0] a, logic [1:0] c, logic [1:0] w);
    chk({req, " valid"}, {63'd0, fwd_valid}, 1);
    chk({req, " err"}, {63'd0, err_valid}, 0);
    chk({req, " addr"}, {32'd0, fwd_addr}, {32'd0, a});
    chk({req, " cmd"}, {62'd0, fwd_cmd}, {62'd0, c});
    chk({req, " win"}, {62'd0, fwd_win}, {62'd0, w});
  endtask

  task automatic expect_err(string req);
    chk({req, " err"}, {63'd0, err_valid}, 1);
    chk({req, " valid"}, {63'd0, fwd_valid}, 0);
  endtask

  // bench-side model of the translations
  function automatic logic [31:0] dmodel(logic [31:0] a, logic [31:0] m, logic [31:0] tb, logic rd);
    logic [31:0] r;
    r = tb + (a - (a & m));
    return rd ? (r >> 6) << 6 : r;
  endfunction
  function automatic logic [31:0] sgmodel(logic [31:0] a, logic [18:0] pfn, logic rd);
    logic [31:0] r;
    r = ({13'd0, pfn} * 32'h2000) + (a % 32'h2000);
    return rd ? (r >> 6) << 6 : r;
  endfunction

  task automatic t_reset();
    chk("R1 valid", {63'd0, fwd_valid}, 0);
    chk("R1 err", {63'd0, err_valid}, 0);
    chk("R1 addr", {32'd0, fwd_addr}, 0);
    chk("R1 cmd/win", {60'd0, fwd_cmd, fwd_win}, 0);
  endtask

  task automatic t_setup();  // R10 register map
    wr_reg(0, 0, 32'h1000_0000); wr_reg(1, 0, 32'hF000_0000); wr_reg(2, 0, 32'h0400_0000); wr_reg(3, 0, 1);
    wr_reg(0, 1, 32'h1000_0000); wr_reg(1, 1, 32'hFF00_0000); wr_reg(2, 1, 32'h8000_0000); wr_reg(3, 1, 1);
    wr_reg(0, 2, 32'h2000_0000); wr_reg(1, 2, 32'hFFF8_0000); wr_reg(3, 2, 3);
    wr_reg(0, 3, 32'h3000_0000); wr_reg(1, 3, 32'hF000_0000); wr_reg(3, 3, 0);
    wr_reg(4, 5, 32'h8001_2345);
    wr_reg(4, 6, 32'h0000_0777);
  endtask

  task automatic t_direct();  // R4 R7 R8
    issue(32'h1234_5678, 1, 0, 0);
    expect_fwd("R4 R7 masked write", dmodel(32'h1234_5678, 32'hF000_0000, 32'h0400_0000, 0), 1, 0);
    issue(32'h1234_5678, 0, 0, 1);
    expect_fwd("R7 R8 locked read", dmodel(32'h1234_5678, 32'hF000_0000, 32'h0400_0000, 1), 3, 0);
    issue(32'h1234_5678, 1, 1, 1);
    expect_fwd("R7 lock ignored on write", dmodel(32'h1234_5678, 32'hF000_0000, 32'h0400_0000, 0), 2, 0);
  endtask

  task automatic t_sg();  // R5 R8 R10
    issue(32'h2000_A123, 1, 1, 0);
    expect_fwd("R5 sg write", sgmodel(32'h2000_A123, 19'h12345, 0), 2, 2);
    issue(32'h2000_A123, 0, 0, 0);
    expect_fwd("R5 R8 sg read", sgmodel(32'h2000_A123, 19'h12345, 1), 0, 2);
  endtask

  task automatic t_errors();  // R2 R6
    issue(32'h3000_0040, 0, 0, 0);
    expect_err("R2 R6 disabled window miss");
    issue(32'h2000_C000, 0, 0, 0);
    expect_err("R6 invalid sg entry");
    @(negedge clk);
    chk("R9 err one cycle", {62'd0, err_valid, fwd_valid}, 0);
  endtask

  task automatic t_priority();  // R3
    issue(32'h10AB_CDEF, 1, 1, 0);
    expect_fwd("R3 lowest wins", dmodel(32'h10AB_CDEF, 32'hF000_0000, 32'h0400_0000, 0), 2, 0);
  endtask

  task automatic t_same_cycle();  // R9 R2
    @(negedge clk);
    cfg_we = 1; cfg_sel = 3; cfg_idx = 0; cfg_wdata = 0;
    req_valid = 1; req_addr = 32'h10AB_CDEF; req_is_write = 1; req_full = 1; req_lock = 0;
    @(negedge clk);
    cfg_we = 0; req_valid = 0;
    expect_fwd("R9 old config used", dmodel(32'h10AB_CDEF, 32'hF000_0000, 32'h0400_0000, 0), 2, 0);
    issue(32'h10AB_CDEF, 1, 1, 0);
    expect_fwd("R2 R9 disabled w0, w1 takes over", dmodel(32'h10AB_CDEF, 32'hFF00_0000, 32'h8000_0000, 0), 2, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_setup();
    t_direct();
    t_sg();
    t_errors();
    t_priority();
    t_same_cycle();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule